// File: doc/BRIEF.md
# Instruction Pairing Cycle Accumulator

This block charges processor cycle costs one instruction at a time. Each accepted instruction brings a raw cost, a family index and an extra bus penalty of 0, 2 or 4 cycles. Costs are normally rounded up to a multiple of four, because the bus works in four-cycle slots. Some adjacent pairs of instructions, each costing 4n+2, can share a slot and so save cycles. A programmable family-by-family table says which pairs may do this.

The block remembers the unrounded cost and the family of the last instruction that was charged in pairing mode. It decides whether the new instruction pairs with that one and works out the charge. The charge is shifted right by a frequency shift. The shifted amount is then added to a global cycle counter and taken off a pending-interrupt countdown. A mode input selects a plain path, which only rounds the raw cost and leaves the pairing history alone.

Top module: `cyc_pair_acc`

## Requirements
- R1: After reset, the counters, the charge output, the pair flag, the stored history cost and every table entry are zero, so the first instruction never pairs.
- R2: In pairing mode, an instruction pairs only if all three of these hold: the table entry at row = stored family and column = current family is 1; the stored cost mod 4 is 2; and either the current raw cost mod 4 is 2 or the penalty is nonzero.
- R3: A paired instruction whose raw cost mod 4 is 2 is charged its raw cost minus 2, with no rounding.
- R4: A paired instruction whose raw cost mod 4 is not 2 (the penalty path) is charged its raw cost unchanged.
- R5: An unpaired instruction in pairing mode is charged (raw cost + penalty) rounded up to the next multiple of 4.
- R6: Each instruction in pairing mode stores raw cost + penalty, unrounded, together with its family, for the next decision. An instruction in plain mode leaves this stored history unchanged.
- R7: The charge shifted right by `freq_shift` is added to `global_cnt`. The `charged` output shows the charge before the shift.
- R8: The same shifted amount is subtracted from `pend_cnt`, modulo 2^32. `pend_load` loads `pend_value`. A load in the same cycle as an instruction gives `pend_value` minus that instruction's shifted charge.
- R9: In plain mode (`mode_pair`=0) the charge is the raw cost rounded up to a multiple of 4. The penalty and the table are ignored, and `paired` is 0.
- R10: A table write (`tbl_we`, `tbl_row`, `tbl_col`, `tbl_bit`) takes effect from the next cycle on. An instruction sampled in the same cycle as the write sees the old entry.
- R11: The results are registered. `out_valid`, `charged`, `paired` and the counters change at the clock edge that samples `in_valid`. Cycles without `in_valid` leave both counters unchanged and hold `out_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction cost is presented |
| in_cost | input | CYC_W | Raw cycle cost |
| in_family | input | FAM_W | Instruction family index |
| in_penalty | input | 3 | Bus penalty: 0, 2 or 4 |
| mode_pair | input | 1 | 1 = pairing rules, 0 = plain rounding |
| freq_shift | input | SH_W | Right shift applied to the charge |
| tbl_we | input | 1 | Pairing table write strobe |
| tbl_row | input | FAM_W | Table row (previous family) |
| tbl_col | input | FAM_W | Table column (current family) |
| tbl_bit | input | 1 | Value written to the table entry |
| pend_load | input | 1 | Load the pending-interrupt countdown |
| pend_value | input | CNT_W | Value loaded into the countdown |
| out_valid | output | 1 | A charge was applied at the last edge |
| charged | output | CYC_W+1 | Charge before the shift |
| paired | output | 1 | The last instruction paired |
| global_cnt | output | CNT_W | Global cycle counter |
| pend_cnt | output | CNT_W | Pending-interrupt countdown |

## Verification
Two pairs of operations can fall in the same clock edge. A table write can arrive together with an instruction that reads the same entry, and a countdown load can arrive together with an instruction charge. The bench provokes both by raising the write strobe or the load strobe in the same cycle as `in_valid`. In the first case it expects the old table value: no pairing on that instruction, and pairing on a later one. In the second case it expects the loaded value minus the shifted charge.

// File: rtl/cyc_pair_pkg.sv
package cyc_pair_pkg;

  // Round a cost up to the next multiple of four.
  function automatic logic [31:0] round_up4(input logic [31:0] x);
    logic [31:0] s;
    s = x + 32'd3;
    return {s[31:2], 2'b00};
  endfunction

  // Pairing decision from its three conditions.
  function automatic logic pair_rule(input logic table_bit,
                                     input logic [1:0] prev_low,
                                     input logic [1:0] cost_low,
                                     input logic [2:0] pen);
    return table_bit && (prev_low == 2'd2) && ((cost_low == 2'd2) || (pen != 3'd0));
  endfunction

  // Charge for an instruction, given the decision and the mode.
  function automatic logic [31:0] charge_of(input logic plain,
                                            input logic paired,
                                            input logic [31:0] cost,
                                            input logic [2:0] pen);
    if (plain)
      return round_up4(cost);
    else if (paired)
      return (cost[1:0] == 2'd2) ? cost - 32'd2 : cost;
    else
      return round_up4(cost + {29'd0, pen});
  endfunction

endpackage

// File: rtl/cyc_pair_table.sv
module cyc_pair_table #(
  parameter int FAM_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [FAM_W-1:0] wr_row,
  input  logic [FAM_W-1:0] wr_col,
  input  logic             wr_bit,
  input  logic [FAM_W-1:0] rd_row,
  input  logic [FAM_W-1:0] rd_col,
  output logic             rd_bit
);
  localparam int NFAM = 1 << FAM_W;

  logic [NFAM-1:0] rows [NFAM];

  for (genvar r = 0; r < NFAM; r++) begin : g_row
    always_ff @(posedge clk) begin
      if (!rst_n)
        rows[r] <= '0;
      else if (we && (wr_row == FAM_W'(r)))
        rows[r][wr_col] <= wr_bit;
    end
  end

  assign rd_bit = rows[rd_row][rd_col];
endmodule

// File: rtl/cyc_pair_decide.sv
module cyc_pair_decide
  import cyc_pair_pkg::*;
#(
  parameter int CYC_W = 16,
  localparam int CHG_W = CYC_W + 1
) (
  input  logic             valid,
  input  logic             mode_pair,
  input  logic [CYC_W-1:0] cost,
  input  logic [2:0]       pen,
  input  logic [1:0]       prev_low,
  input  logic             table_bit,
  output logic             pair_hit,
  output logic [CHG_W-1:0] charge
);
  logic [31:0] cost32;
  logic [31:0] chg32;

  always_comb begin
    cost32   = 32'(cost);
    pair_hit = valid && mode_pair && pair_rule(table_bit, prev_low, cost[1:0], pen);
    chg32    = charge_of(!mode_pair, pair_hit, cost32, pen);
    charge   = chg32[CHG_W-1:0];
  end
endmodule

// File: rtl/cyc_pair_count.sv
module cyc_pair_count #(
  parameter int CHG_W = 17,
  parameter int CNT_W = 32,
  parameter int SH_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_en,
  input  logic [CHG_W-1:0] amount,
  input  logic [SH_W-1:0]  shift,
  input  logic             load,
  input  logic [CNT_W-1:0] load_value,
  output logic [CNT_W-1:0] global_cnt,
  output logic [CNT_W-1:0] pend_cnt
);
  logic [CNT_W-1:0] scaled;
  logic [CNT_W-1:0] pend_base;

  assign scaled    = add_en ? CNT_W'(amount >> shift) : '0;
  assign pend_base = load ? load_value : pend_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      global_cnt <= '0;
      pend_cnt   <= '0;
    end else begin
      global_cnt <= global_cnt + scaled;
      pend_cnt   <= pend_base - scaled;
    end
  end
endmodule

// File: rtl/cyc_pair_acc.sv
module cyc_pair_acc #(
  parameter int CYC_W = 16,
  parameter int FAM_W = 6,
  parameter int CNT_W = 32,
  parameter int SH_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [CYC_W-1:0]   in_cost,
  input  logic [FAM_W-1:0]   in_family,
  input  logic [2:0]         in_penalty,
  input  logic               mode_pair,
  input  logic [SH_W-1:0]    freq_shift,
  input  logic               tbl_we,
  input  logic [FAM_W-1:0]   tbl_row,
  input  logic [FAM_W-1:0]   tbl_col,
  input  logic               tbl_bit,
  input  logic               pend_load,
  input  logic [CNT_W-1:0]   pend_value,
  output logic               out_valid,
  output logic [CYC_W:0]     charged,
  output logic               paired,
  output logic [CNT_W-1:0]   global_cnt,
  output logic [CNT_W-1:0]   pend_cnt
);
  localparam int CHG_W = CYC_W + 1;

  // Stored history of the last instruction charged in pairing mode.
  logic [CHG_W-1:0] hist_cost;
  logic [FAM_W-1:0] hist_fam;

  // Named internal events for the checker.
  logic             lookup_bit;
  logic             pair_hit;
  logic [CHG_W-1:0] charge_now;
  logic [1:0]       hist_low;

  assign hist_low = hist_cost[1:0];

  cyc_pair_table #(.FAM_W(FAM_W)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (tbl_we),
    .wr_row (tbl_row),
    .wr_col (tbl_col),
    .wr_bit (tbl_bit),
    .rd_row (hist_fam),
    .rd_col (in_family),
    .rd_bit (lookup_bit)
  );

  cyc_pair_decide #(.CYC_W(CYC_W)) u_decide (
    .valid     (in_valid),
    .mode_pair (mode_pair),
    .cost      (in_cost),
    .pen       (in_penalty),
    .prev_low  (hist_low),
    .table_bit (lookup_bit),
    .pair_hit  (pair_hit),
    .charge    (charge_now)
  );

  cyc_pair_count #(.CHG_W(CHG_W), .CNT_W(CNT_W), .SH_W(SH_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .add_en     (in_valid),
    .amount     (charge_now),
    .shift      (freq_shift),
    .load       (pend_load),
    .load_value (pend_value),
    .global_cnt (global_cnt),
    .pend_cnt   (pend_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_cost <= '0;
      hist_fam  <= '0;
      out_valid <= 1'b0;
      paired    <= 1'b0;
      charged   <= '0;
    end else begin
      out_valid <= in_valid;
      paired    <= pair_hit;
      if (in_valid)
        charged <= charge_now;
      if (in_valid && mode_pair) begin
        hist_cost <= CHG_W'(in_cost) + CHG_W'(in_penalty);
        hist_fam  <= in_family;
      end
    end
  end
endmodule

// File: rtl/cyc_pair_chk.sv
module cyc_pair_chk #(
  parameter int CYC_W = 16,
  parameter int CNT_W = 32,
  parameter int SH_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             mode_pair,
  input logic [SH_W-1:0]  freq_shift,
  input logic             pend_load,
  input logic             out_valid,
  input logic             paired,
  input logic [CYC_W:0]   charged,
  input logic [CNT_W-1:0] global_cnt,
  input logic [CNT_W-1:0] pend_cnt,
  input logic             pair_hit,
  input logic             lookup_bit,
  input logic [1:0]       hist_low
);
  // R2
  pair_needs_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pair_hit |-> (lookup_bit && hist_low == 2'd2));

  // R9
  plain_never_pairs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !mode_pair) |=> !paired);

  // R5
  unpaired_rounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !paired) |-> (charged[1:0] == 2'b00));

  // R7
  global_adds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (global_cnt == $past(global_cnt) + CNT_W'(charged >> $past(freq_shift))));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(global_cnt) && !out_valid));

  // R8
  pend_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pend_load) |=> (pend_cnt == $past(pend_cnt) - CNT_W'(charged >> $past(freq_shift))));
endmodule

bind cyc_pair_acc cyc_pair_chk #(.CYC_W(CYC_W), .CNT_W(CNT_W), .SH_W(SH_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .mode_pair  (mode_pair),
  .freq_shift (freq_shift),
  .pend_load  (pend_load),
  .out_valid  (out_valid),
  .paired     (paired),
  .charged    (charged),
  .global_cnt (global_cnt),
  .pend_cnt   (pend_cnt),
  .pair_hit   (pair_hit),
  .lookup_bit (lookup_bit),
  .hist_low   (hist_low)
);

// File: tb/sim_cyc_pair_acc.sv
module sim_cyc_pair_acc;
  localparam int CYC_W = 16;
  localparam int FAM_W = 6;
  localparam int CNT_W = 32;
  localparam int SH_W  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [CYC_W-1:0] in_cost = '0;
  logic [FAM_W-1:0] in_family = '0;
  logic [2:0] in_penalty = '0;
  logic mode_pair = 1'b1;
  logic [SH_W-1:0] freq_shift = '0;
  logic tbl_we = 1'b0;
  logic [FAM_W-1:0] tbl_row = '0;
  logic [FAM_W-1:0] tbl_col = '0;
  logic tbl_bit = 1'b0;
  logic pend_load = 1'b0;
  logic [CNT_W-1:0] pend_value = '0;
  logic out_valid;
  logic [CYC_W:0] charged;
  logic paired;
  logic [CNT_W-1:0] global_cnt;
  logic [CNT_W-1:0] pend_cnt;

  always #10 clk = ~clk;

  cyc_pair_acc #(.CYC_W(CYC_W), .FAM_W(FAM_W), .CNT_W(CNT_W), .SH_W(SH_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cost(in_cost),
    .in_family(in_family), .in_penalty(in_penalty), .mode_pair(mode_pair),
    .freq_shift(freq_shift), .tbl_we(tbl_we), .tbl_row(tbl_row), .tbl_col(tbl_col),
    .tbl_bit(tbl_bit), .pend_load(pend_load), .pend_value(pend_value),
    .out_valid(out_valid), .charged(charged), .paired(paired),
    .global_cnt(global_cnt), .pend_cnt(pend_cnt)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [CNT_W-1:0] exp_global = '0;
  logic [CNT_W-1:0] exp_pend   = '0;
  // Same-cycle side operations for the next issue.
  bit co_load = 0;
  logic [CNT_W-1:0] co_val = '0;
  bit co_we = 0;
  int co_row = 0, co_col = 0;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tbl_set(input int r, input int c, input bit b);
    @(negedge clk);
    tbl_we = 1; tbl_row = FAM_W'(r); tbl_col = FAM_W'(c); tbl_bit = b;
    @(negedge clk);
    tbl_we = 0;
  endtask

  task automatic issue(input int cost, input int fam, input int pen,
                       input int exp_chg, input bit exp_pair, input string req);
    logic [CNT_W-1:0] sc;
    @(negedge clk);
    in_valid = 1; in_cost = CYC_W'(cost); in_family = FAM_W'(fam); in_penalty = 3'(pen);
    if (co_load) begin pend_load = 1; pend_value = co_val; end
    if (co_we) begin tbl_we = 1; tbl_row = FAM_W'(co_row); tbl_col = FAM_W'(co_col); tbl_bit = 1; end
    @(negedge clk);
    in_valid = 0; pend_load = 0; tbl_we = 0;
    sc = CNT_W'(exp_chg) >> freq_shift;
    exp_global = exp_global + sc;
    exp_pend = (co_load ? co_val : exp_pend) - sc;
    co_load = 0; co_we = 0;
    check(req, "charged", longint'(charged), longint'(exp_chg));
    check(req, "paired", longint'(paired), longint'(exp_pair));
    check(req, "out_valid", longint'(out_valid), 1);
    check(req, "global_cnt", longint'(global_cnt), longint'(exp_global));
    check(req, "pend_cnt", longint'(pend_cnt), longint'(exp_pend));
  endtask

  task automatic t_reset();
    check("R1", "global_cnt", longint'(global_cnt), 0);
    check("R1", "pend_cnt", longint'(pend_cnt), 0);
    check("R1", "charged", longint'(charged), 0);
    check("R1", "paired", longint'(paired), 0);
    check("R1", "out_valid", longint'(out_valid), 0);
  endtask

  task automatic t_basic_pair();
    tbl_set(0, 0, 1);
    issue(14, 0, 0, 16, 0, "R1_first");
    issue(14, 0, 0, 12, 1, "R3");          // 14 + 14 -> 28 in total
  endtask

  task automatic t_table_gate();
    issue(14, 1, 0, 16, 0, "R2_setup");
    issue(14, 2, 0, 16, 0, "R2_table");   // entry [1][2] is 0
  endtask

  task automatic t_prev_not2();
    tbl_set(3, 3, 1);
    issue(20, 3, 0, 20, 0, "R5");
    issue(14, 3, 0, 16, 0, "R2_prev");    // stored 20 mod 4 = 0
  endtask

  task automatic t_penalty_pair();
    tbl_set(4, 5, 1);
    issue(14, 4, 0, 16, 0, "R5");
    issue(24, 5, 4, 24, 1, "R4");         // 16 + 24 -> 40
  endtask

  task automatic t_stored_with_pen();
    tbl_set(6, 7, 1);
    issue(20, 6, 2, 24, 0, "R5_pen");     // stores 22
    issue(14, 7, 0, 12, 1, "R6");         // 24 + 12 -> 36
    issue(16, 7, 0, 16, 0, "R2_cur4n");   // no table [7][7], and 16 mod 4 = 0
  endtask

  task automatic t_plain_mode();
    tbl_set(8, 8, 1);
    tbl_set(8, 9, 1);
    issue(14, 8, 0, 16, 0, "R5");
    @(negedge clk); mode_pair = 0;
    issue(14, 9, 4, 16, 0, "R9");         // table [8][9] set, but ignored
    issue(13, 9, 4, 16, 0, "R9_pen");     // penalty ignored
    @(negedge clk); mode_pair = 1;
    issue(14, 8, 0, 12, 1, "R6_plain");   // history still holds 14 from family 8
  endtask

  task automatic t_shift();
    tbl_set(10, 10, 1);
    @(negedge clk); freq_shift = 2'd2;
    issue(14, 10, 0, 16, 0, "R7");
    issue(14, 10, 0, 12, 1, "R7_pair");
    @(negedge clk); freq_shift = 2'd0;
  endtask

  task automatic t_table_same_cycle();
    issue(14, 11, 0, 16, 0, "R10_setup");
    co_we = 1; co_row = 11; co_col = 12;
    issue(14, 12, 0, 16, 0, "R10_old");   // write in the same cycle: old entry 0
    issue(14, 11, 0, 16, 0, "R10_mid");   // entry [12][11] is 0
    issue(14, 12, 0, 12, 1, "R10_new");
  endtask

  task automatic t_pend();
    @(negedge clk); pend_load = 1; pend_value = 32'd1000;
    @(negedge clk); pend_load = 0;
    exp_pend = 32'd1000;
    check("R8", "pend_load", longint'(pend_cnt), 1000);
    issue(7, 20, 0, 8, 0, "R8_sub");
    co_load = 1; co_val = 32'd500;
    issue(15, 20, 0, 16, 0, "R8_same");    // 500 - 16
  endtask

  task automatic t_idle();
    logic [CNT_W-1:0] g;
    g = global_cnt;
    repeat (3) @(negedge clk);
    check("R11", "global idle", longint'(global_cnt), longint'(g));
    check("R11", "pend idle", longint'(pend_cnt), longint'(exp_pend));
    check("R11", "out_valid idle", longint'(out_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_basic_pair();
    t_table_gate();
    t_prev_not2();
    t_penalty_pair();
    t_stored_with_pen();
    t_plain_mode();
    t_shift();
    t_table_same_cycle();
    t_pend();
    t_idle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule